// File: doc/BRIEF.md
# Oversampled Type B Frame Encoder

This block turns a short byte frame into the chip stream that a proximity card sends back to a reader. Each logical bit becomes a fixed number of identical chips, four by default. The bytes arrive with their CRC already appended. They are written one at a time into a 64-entry internal store through a valid/ready byte port. A start pulse, together with a byte count, launches transmission.

Once launched, the encoder walks through a fixed sequence of segments:

- a run of ones that lets the reader lock its phase;
- the start-of-frame mark: a low run, then a short high run;
- one ten-bit character per byte: a 0 start bit, the eight data bits least significant first, and a 1 stop bit;
- the end-of-frame mark: a low run, then a high run;
- a few trailing idle chips.

The sequence advances by one chip on each cycle where the chip-rate enable is high. A busy flag covers the whole transfer. A one-cycle done pulse marks its end. When not busy, the output rests at 1. CRC generation, subcarrier modulation and the analog path belong to other blocks.

Top module: `frame_chip_encoder`

## Requirements
- R1: After reset, chip_out is 1, busy is 0, done is 0 and in_ready is 1.
- R2: The first 80 chips of an accepted frame are 1 (20 logical ones).
- R3: The preamble is followed by 40 chips of 0, then 8 chips of 1 (10 logical zeros, then 2 logical ones).
- R4: Each payload byte is sent as 4 chips of 0, then its 8 data bits least significant first with each bit held for 4 chips, then 4 chips of 1. Bytes go out in load order, starting from the first byte loaded after the previous accepted start (or after reset).
- R5: After the last byte come 40 chips of 0, then 40 chips of 1.
- R6: After the end-of-frame mark come 8 chips of 1, still under busy. The chip-enable cycle that consumes the last of these chips drops busy in the next cycle.
- R7: The chip sequence advances only on cycles where chip_en is 1. When chip_en is 0 during busy, chip_out and busy hold their values.
- R8: busy is 1 from the cycle after an accepted start until the final trailing chip has been consumed. done is a single-cycle pulse in the first cycle that busy is 0 again.
- R9: A start pulse with frame_len of 0 or above 64 is ignored: busy stays 0.
- R10: A start pulse while busy is ignored. The running frame keeps its length and content.
- R11: in_ready equals not busy. A byte is stored when in_valid and in_ready are both 1. A byte offered in the same cycle as an accepted start belongs to that frame. The write position returns to entry 0 on every accepted start and wraps from entry 63 to entry 0. Bytes offered while busy are dropped.
- R12: chip_en in the same cycle as an accepted start does not advance the sequence. The first chip is therefore held for a full 80 enables of preamble before the first zero chip.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Payload byte offered |
| in_data | input | 8 | Payload byte |
| in_ready | output | 1 | Byte can be stored (encoder idle) |
| frame_len | input | 7 | Number of bytes to send, 1 to 64 |
| start | input | 1 | Launch a frame of frame_len bytes |
| chip_en | input | 1 | Chip-rate enable |
| chip_out | output | 1 | Current output chip |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse when a frame completes |

## Verification
Two pairs of events can land in the same cycle, and the bench provokes both.

The first pair is a byte load and an accepted start. The bench raises in_valid and start together. It then expects that byte to appear as the last character of the launched frame, and the next frame to draw again from entry 0.

The second pair is a chip enable and an accepted start. The bench drives chip_en by hand in the start cycle. It then counts exactly 79 further enables to the last preamble chip and one more to the first zero, so a start that consumed a chip would be caught.

A start pulse that overlaps a running frame is judged against the per-cycle reference model. Any change in length or content is reported as a mismatch.

// File: rtl/fce_pkg.sv
package fce_pkg;

    typedef enum logic [2:0] {
        SEG_IDLE,
        SEG_PRE,
        SEG_SOF_LO,
        SEG_SOF_HI,
        SEG_CHAR,
        SEG_EOF_LO,
        SEG_EOF_HI,
        SEG_TAIL
    } seg_e;

    // start bit + 8 data bits + stop bit
    localparam int CHAR_BITS = 10;

endpackage

// File: rtl/fce_byte_buf.sv
module fce_byte_buf #(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [7:0]    wr_data,
    input  logic          ptr_clear,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wr_ptr_d, wr_ptr_q;

    always_comb begin
        wr_ptr_d = wr_ptr_q;
        if (wr_en) begin
            wr_ptr_d = (wr_ptr_q == AW'(DEPTH - 1)) ? '0 : wr_ptr_q + AW'(1);
        end
        if (ptr_clear) begin
            wr_ptr_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
        end else begin
            wr_ptr_q <= wr_ptr_d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_ptr_q] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/fce_seq.sv
module fce_seq
    import fce_pkg::*;
#(
    parameter int DEPTH       = 64,
    parameter int CPB         = 4,
    parameter int PRE_BITS    = 20,
    parameter int SOF_LO_BITS = 10,
    parameter int SOF_HI_BITS = 2,
    parameter int EOF_LO_BITS = 10,
    parameter int EOF_HI_BITS = 10,
    parameter int TAIL_CHIPS  = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int LEN_W = $clog2(DEPTH) + 1,
    localparam int REP_W = (CPB > 1) ? $clog2(CPB) : 1,
    localparam int SPAN  = PRE_BITS + SOF_LO_BITS + SOF_HI_BITS + EOF_LO_BITS
                         + EOF_HI_BITS + TAIL_CHIPS + CHAR_BITS,
    localparam int CNT_W = $clog2(SPAN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] frame_len,
    input  logic             chip_en,
    output logic             accept,
    output logic [AW-1:0]    rd_addr,
    output seg_e             seg,
    output logic [CNT_W-1:0] cnt,
    output logic             busy,
    output logic             done
);

    typedef struct packed {
        seg_e             seg;
        logic [CNT_W-1:0] cnt;
        logic [REP_W-1:0] rep;
        logic [AW-1:0]    idx;
        logic [LEN_W-1:0] len;
        logic             busy;
        logic             done;
    } seq_t;

    seq_t             st_d, st_q;
    logic [CNT_W-1:0] lim;
    logic             last_rep;
    logic             last_cnt;
    logic             last_byte;

    assign accept = start && !st_q.busy && (frame_len != '0)
                 && (frame_len <= LEN_W'(DEPTH));

    always_comb begin
        case (st_q.seg)
            SEG_PRE:    lim = CNT_W'(PRE_BITS - 1);
            SEG_SOF_LO: lim = CNT_W'(SOF_LO_BITS - 1);
            SEG_SOF_HI: lim = CNT_W'(SOF_HI_BITS - 1);
            SEG_CHAR:   lim = CNT_W'(CHAR_BITS - 1);
            SEG_EOF_LO: lim = CNT_W'(EOF_LO_BITS - 1);
            SEG_EOF_HI: lim = CNT_W'(EOF_HI_BITS - 1);
            SEG_TAIL:   lim = CNT_W'(TAIL_CHIPS - 1);
            default:    lim = '0;
        endcase
    end

    // Trailing chips are counted one by one, everything else per logical bit.
    assign last_rep  = (st_q.seg == SEG_TAIL) || (st_q.rep == REP_W'(CPB - 1));
    assign last_cnt  = (st_q.cnt == lim);
    assign last_byte = ({1'b0, st_q.idx} == (st_q.len - LEN_W'(1)));

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (accept) begin
                st_d.seg  = SEG_PRE;
                st_d.cnt  = '0;
                st_d.rep  = '0;
                st_d.idx  = '0;
                st_d.len  = frame_len;
                st_d.busy = 1'b1;
            end
        end else if (chip_en) begin
            if (!last_rep) begin
                st_d.rep = st_q.rep + REP_W'(1);
            end else begin
                st_d.rep = '0;
                if (!last_cnt) begin
                    st_d.cnt = st_q.cnt + CNT_W'(1);
                end else begin
                    st_d.cnt = '0;
                    case (st_q.seg)
                        SEG_PRE:    st_d.seg = SEG_SOF_LO;
                        SEG_SOF_LO: st_d.seg = SEG_SOF_HI;
                        SEG_SOF_HI: st_d.seg = SEG_CHAR;
                        SEG_CHAR: begin
                            if (last_byte) begin
                                st_d.seg = SEG_EOF_LO;
                            end else begin
                                st_d.idx = st_q.idx + AW'(1);
                            end
                        end
                        SEG_EOF_LO: st_d.seg = SEG_EOF_HI;
                        SEG_EOF_HI: st_d.seg = SEG_TAIL;
                        SEG_TAIL: begin
                            st_d.seg  = SEG_IDLE;
                            st_d.busy = 1'b0;
                            st_d.done = 1'b1;
                        end
                        default: begin
                            st_d.seg  = SEG_IDLE;
                            st_d.busy = 1'b0;
                        end
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{seg: SEG_IDLE, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_addr = st_q.idx;
    assign seg     = st_q.seg;
    assign cnt     = st_q.cnt;
    assign busy    = st_q.busy;
    assign done    = st_q.done;

endmodule

// File: rtl/fce_chip_sel.sv
module fce_chip_sel
    import fce_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  seg_e             seg,
    input  logic [CNT_W-1:0] cnt,
    input  logic [7:0]       byte_val,
    output logic             chip
);

    logic [2:0] bit_pos;

    assign bit_pos = 3'(cnt - CNT_W'(1));

    always_comb begin
        case (seg)
            SEG_SOF_LO, SEG_EOF_LO: chip = 1'b0;
            SEG_CHAR: begin
                if (cnt == '0) begin
                    chip = 1'b0;
                end else if (cnt == CNT_W'(CHAR_BITS - 1)) begin
                    chip = 1'b1;
                end else begin
                    chip = byte_val[bit_pos];
                end
            end
            default: chip = 1'b1;
        endcase
    end

endmodule

// File: rtl/frame_chip_encoder.sv
module frame_chip_encoder
    import fce_pkg::*;
#(
    parameter int DEPTH       = 64,
    parameter int CPB         = 4,
    parameter int PRE_BITS    = 20,
    parameter int SOF_LO_BITS = 10,
    parameter int SOF_HI_BITS = 2,
    parameter int EOF_LO_BITS = 10,
    parameter int EOF_HI_BITS = 10,
    parameter int TAIL_CHIPS  = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int LEN_W = $clog2(DEPTH) + 1,
    localparam int SPAN  = PRE_BITS + SOF_LO_BITS + SOF_HI_BITS + EOF_LO_BITS
                         + EOF_HI_BITS + TAIL_CHIPS + CHAR_BITS,
    localparam int CNT_W = $clog2(SPAN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    output logic             in_ready,
    input  logic [LEN_W-1:0] frame_len,
    input  logic             start,
    input  logic             chip_en,
    output logic             chip_out,
    output logic             busy,
    output logic             done
);

    logic             accept;
    logic [AW-1:0]    rd_addr;
    logic [7:0]       rd_data;
    seg_e             seg;
    logic [CNT_W-1:0] cnt;
    logic             busy_int;

    assign in_ready = !busy_int;
    assign busy     = busy_int;

    fce_byte_buf #(
        .DEPTH (DEPTH)
    ) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (in_valid && !busy_int),
        .wr_data   (in_data),
        .ptr_clear (accept),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data)
    );

    fce_seq #(
        .DEPTH       (DEPTH),
        .CPB         (CPB),
        .PRE_BITS    (PRE_BITS),
        .SOF_LO_BITS (SOF_LO_BITS),
        .SOF_HI_BITS (SOF_HI_BITS),
        .EOF_LO_BITS (EOF_LO_BITS),
        .EOF_HI_BITS (EOF_HI_BITS),
        .TAIL_CHIPS  (TAIL_CHIPS)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .frame_len (frame_len),
        .chip_en   (chip_en),
        .accept    (accept),
        .rd_addr   (rd_addr),
        .seg       (seg),
        .cnt       (cnt),
        .busy      (busy_int),
        .done      (done)
    );

    fce_chip_sel #(
        .CNT_W (CNT_W)
    ) u_sel (
        .seg      (seg),
        .cnt      (cnt),
        .byte_val (rd_data),
        .chip     (chip_out)
    );

endmodule

// File: rtl/fce_chk.sv
module fce_chk #(
    parameter int LEN_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [LEN_W-1:0] frame_len,
    input logic             chip_en,
    input logic             chip_out,
    input logic             busy,
    input logic             done
);

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    end_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !chip_en) |=> (busy && $stable(chip_out)));

    // R10
    ignore_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !chip_en) |=> busy);

    // R9
    zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && (frame_len == '0)) |=> !busy);

    // R2
    first_chip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> chip_out);

endmodule

bind frame_chip_encoder fce_chk #(.LEN_W(LEN_W)) u_fce_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .frame_len (frame_len),
    .chip_en   (chip_en),
    .chip_out  (chip_out),
    .busy      (busy),
    .done      (done)
);

// File: tb/frame_chip_encoder_tb_top.sv
`timescale 1ns/1ps
module frame_chip_encoder_tb_top;

    localparam int DEPTH = 64;
    localparam int CPB   = 4;
    localparam int TAILC = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_ready;
    logic [6:0] frame_len = '0;
    logic       start = 1'b0;
    logic       chip_en = 1'b0;
    logic       chip_out, busy, done;

    always #4 clk = ~clk;

    frame_chip_encoder dut_i (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_data (in_data),
        .in_ready (in_ready), .frame_len (frame_len), .start (start),
        .chip_en (chip_en), .chip_out (chip_out), .busy (busy), .done (done)
    );

    int n_chk  = 0;
    int n_fail = 0;
    int ce_mode = 3;
    int cyc = 0;
    logic [15:0] lfsr = 16'hACE1;
    bit chk_on = 1'b0;

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    bit         m_busy = 1'b0, m_done = 1'b0;
    int         m_idx = 0;
    int         m_wr = 0;
    bit         chips[$];
    string      tags[$];
    logic [7:0] mmem[DEPTH];

    function automatic void push(bit v, int nbits, string t);
        repeat (nbits * CPB) begin
            chips.push_back(v);
            tags.push_back(t);
        end
    endfunction

    function automatic void build(int len);
        chips.delete();
        tags.delete();
        push(1'b1, 20, "R2");
        push(1'b0, 10, "R3");
        push(1'b1, 2, "R3");
        for (int b = 0; b < len; b++) begin
            push(1'b0, 1, "R4");
            for (int j = 0; j < 8; j++) push(mmem[b][j], 1, "R4");
            push(1'b1, 1, "R4");
        end
        push(1'b0, 10, "R5");
        push(1'b1, 10, "R5");
        repeat (TAILC) begin
            chips.push_back(1'b1);
            tags.push_back("R6");
        end
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 1'b0;
            m_done = 1'b0;
            m_wr   = 0;
        end else begin
            m_done = 1'b0;
            if (!m_busy) begin
                if (in_valid) begin
                    mmem[m_wr] = in_data;
                    m_wr = (m_wr + 1) % DEPTH;
                end
                if (start && frame_len >= 1 && frame_len <= DEPTH) begin
                    build(int'(frame_len));
                    m_busy = 1'b1;
                    m_idx  = 0;
                    m_wr   = 0;
                end
            end else if (chip_en) begin
                m_idx++;
                if (m_idx == chips.size()) begin
                    m_busy = 1'b0;
                    m_done = 1'b1;
                end
            end
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && chk_on) begin
            chk(m_busy ? tags[m_idx] : "R8 idle", int'(chip_out),
                m_busy ? int'(chips[m_idx]) : 1);
            chk("R8 busy", int'(busy), int'(m_busy));
            chk("R8 done", int'(done), int'(m_done));
            chk("R11 ready", int'(in_ready), int'(!m_busy));
        end
    end

    // Chip enable patterns; mode 3 leaves chip_en to the tasks
    always @(negedge clk) begin
        cyc++;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (ce_mode)
            0: chip_en = 1'b1;
            1: chip_en = (cyc % 3 == 0);
            2: chip_en = lfsr[0];
            default: ;
        endcase
    end

    task automatic load(logic [7:0] b);
        in_valid = 1'b1;
        in_data  = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic fire(int len);
        frame_len = 7'(len);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        int g = 0;
        while (busy && g < 40000) begin
            @(negedge clk);
            g++;
        end
        chk("R8 frame ends", int'(busy), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 chip_out", int'(chip_out), 1);
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 in_ready", int'(in_ready), 1);
        chk_on = 1'b1;

        // R12 / R7: chip_en in the start cycle, then hand-driven enables
        load(8'hA5);
        frame_len = 7'd1;
        start = 1'b1;
        chip_en = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chip_en = 1'b0;
        chk("R12 busy after start", int'(busy), 1);
        chk("R12 first chip", int'(chip_out), 1);
        repeat (2) @(negedge clk);
        chk("R7 held without enable", int'(chip_out), 1);
        chip_en = 1'b1;
        repeat (79) @(negedge clk);
        chk("R12 last preamble chip", int'(chip_out), 1);
        @(negedge clk);
        chk("R12 first SOF chip", int'(chip_out), 0);
        ce_mode = 0;
        wait_idle();

        // R4 / R11: three bytes, sparse enables, bytes offered while busy dropped
        ce_mode = 1;
        load(8'h00);
        load(8'hFF);
        load(8'h3C);
        fire(3);
        load(8'h77);
        load(8'h99);
        wait_idle();

        // R9: illegal lengths ignored
        fire(0);
        @(negedge clk);
        chk("R9 zero length", int'(busy), 0);
        fire(65);
        @(negedge clk);
        chk("R9 oversize length", int'(busy), 0);
        ce_mode = 2;
        load(8'h5A);
        load(8'hC3);
        fire(2);
        wait_idle();

        // R10: start while busy ignored
        ce_mode = 0;
        load(8'h81);
        fire(1);
        repeat (10) @(negedge clk);
        fire(5);
        chk("R10 still busy", int'(busy), 1);
        wait_idle();
        repeat (2) @(negedge clk);
        chk("R10 no late start", int'(busy), 0);

        // R11: byte offered in the start cycle joins the frame
        load(8'h11);
        in_valid = 1'b1;
        in_data = 8'h22;
        frame_len = 7'd2;
        start = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        start = 1'b0;
        chk("R11 start with byte", int'(busy), 1);
        wait_idle();
        // back-to-back start in the done cycle, buffer reused from entry 0
        fire(2);
        wait_idle();

        // R11: write position wraps at 64
        for (int i = 0; i < 66; i++) load(8'(i * 3 + 1));
        fire(2);
        wait_idle();

        // R4: full 64-byte frame
        ce_mode = 2;
        for (int i = 0; i < 64; i++) load(8'(i * 37 + 5));
        fire(64);
        wait_idle();

        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule